// File: doc/BRIEF.md
# Target Transfer Halt Controller

This block decides when a bus port working as a target should stop a data transfer that is already running. Two things can start a stop: a one-cycle error pulse from the parity, CRC or integrity checkers, or the initiator raising its attention line. The stop does not take effect at once. The block first lets a few more bytes through so the internal logic can settle. In synchronous mode it then waits for the outstanding offset to drain to zero. When the port is receiving, it also asks for the receive FIFO to be flushed to memory. Only after these steps does it report the halt as complete.

A single disable bit turns the whole mechanism off. When the port runs as an initiator, nothing here ever fires. The byte stream is observed as a plain strobe, with one pulse for each byte moved on the bus. The block never applies back-pressure to that stream. It only raises `stop_req` for the phase logic to act on, so every control and status pin is a plain level or pulse.

A completed halt stays latched, together with a code that records the first trigger, until software pulses `clear_halt`.

Top module: `xfer_halt_ctrl`

## Requirements
- R1: After reset, `stop_req`, `flush_req` and `halted` are low and `halt_cause` is 2'b00.
- R2: In target mode with `halt_disable` low, a pulse on `err_pulse` arms a halt and `halt_cause` reads 2'b01 from the next cycle on.
- R3: In target mode with `halt_disable` low, `atn` high arms a halt with `halt_cause` 2'b10. If `atn` and `err_pulse` arrive in the same cycle, `halt_cause` is 2'b11.
- R4: While `halt_disable` is high, neither `err_pulse` nor `atn` arms a halt. `stop_req` stays low and `halt_cause` stays 2'b00.
- R5: While `target_mode` is low, no halt is armed, whatever the state of `halt_disable`.
- R6: Once armed, `stop_req` stays low through the first GRACE_MAX-1 byte strobes (default 3). It rises in the cycle after the edge that samples strobe number GRACE_MAX.
- R7: If no byte strobe is seen for IDLE_LIMIT consecutive armed cycles (default 8), the grace period ends as if it had been used up.
- R8: With `sync_mode` high, after the grace period `stop_req` is high but `halted` stays low while `offset_cnt` is non-zero. The block moves on in the cycle after `offset_cnt` is sampled as zero.
- R9: With `rx_dir` high, after the grace period and any offset drain, `flush_req` is high until `fifo_empty` is sampled high, and `halted` rises on the next cycle. With `rx_dir` low, `flush_req` never rises.
- R10: `halt_cause` keeps its first value while a halt is in progress or held. Later triggers do not change it, and `clear_halt` clears it to 2'b00.
- R11: `halted` and `stop_req` stay high until `clear_halt` is sampled high while halted. After that the block returns to idle and can be armed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| target_mode | input | 1 | 1 = port acts as target, 0 = initiator |
| halt_disable | input | 1 | 1 = ignore errors and attention |
| sync_mode | input | 1 | 1 = synchronous transfer, so offsets must drain |
| rx_dir | input | 1 | 1 = port is receiving data |
| byte_strobe | input | 1 | One pulse per byte moved on the bus |
| err_pulse | input | 1 | Parity, CRC or integrity error detected |
| atn | input | 1 | Attention line from the initiator |
| offset_cnt | input | OFS_W | Outstanding synchronous offset count |
| fifo_empty | input | 1 | Receive FIFO holds no data |
| clear_halt | input | 1 | Pulse to release a held halt |
| stop_req | output | 1 | Request to stop the transfer |
| flush_req | output | 1 | Request to flush the receive FIFO to memory |
| halted | output | 1 | Halt complete |
| halt_cause | output | 2 | 01 error, 10 attention, 11 both at once, 00 none |

## Verification
The bench counts grace strobes exactly. A design that stops one byte early or one byte late shows `stop_req` rising on the wrong edge. It holds `offset_cnt` non-zero and `fifo_empty` low for several cycles, so a design that skips the drain or flush steps, or skips them in the wrong direction, reports `halted` too early or raises `flush_req` during a send. It fires a second trigger while a halt is held, which catches a cause register that gets overwritten. It also checks that a halt stays latched until cleared. The idle-timeout path and the both-at-once cause code get their own scenarios, because a design that misses either one would hang in the armed state or report a single cause.

// File: rtl/xfer_halt_pkg.sv
package xfer_halt_pkg;
  typedef enum logic [2:0] {
    HS_IDLE   = 3'd0,
    HS_ARMED  = 3'd1,
    HS_DRAIN  = 3'd2,
    HS_FLUSH  = 3'd3,
    HS_HALTED = 3'd4
  } halt_state_e;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_ERR  = 2'b01;
  localparam logic [1:0] CAUSE_ATN  = 2'b10;
  localparam logic [1:0] CAUSE_BOTH = 2'b11;
endpackage

// File: rtl/halt_trigger.sv
module halt_trigger (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       target_mode,
  input  logic       halt_disable,
  input  logic       err_pulse,
  input  logic       atn,
  input  logic       is_idle,
  input  logic       release_i,
  output logic       fire,
  output logic [1:0] cause
);
  import xfer_halt_pkg::*;

  assign fire = is_idle && target_mode && !halt_disable && (err_pulse || atn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= CAUSE_NONE;
    end else if (fire) begin
      cause <= {atn, err_pulse};
    end else if (release_i) begin
      cause <= CAUSE_NONE;
    end
  end

  // R10: outside idle and release, the recorded cause never moves
  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_idle && !release_i) |=> $stable(cause));
endmodule

// File: rtl/grace_counter.sv
module grace_counter #(
  parameter int GRACE_MAX  = 3,
  parameter int IDLE_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic byte_strobe,
  output logic done
);
  localparam int GW = (GRACE_MAX > 1) ? $clog2(GRACE_MAX) : 1;
  localparam int IW = (IDLE_LIMIT > 1) ? $clog2(IDLE_LIMIT) : 1;
  localparam logic [GW-1:0] G_LAST = GW'(GRACE_MAX - 1);
  localparam logic [IW-1:0] I_LAST = IW'(IDLE_LIMIT - 1);

  logic [GW-1:0] grace_q;
  logic [IW-1:0] quiet_q;

  assign done = active && ((byte_strobe && grace_q == G_LAST) ||
                           (!byte_strobe && quiet_q == I_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace_q <= '0;
      quiet_q <= '0;
    end else if (!active || done) begin
      grace_q <= '0;
      quiet_q <= '0;
    end else if (byte_strobe) begin
      grace_q <= grace_q + 1'b1;
      quiet_q <= '0;
    end else begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  // R6: the grace count never passes its last legal value
  a_r6_grace_bound: assert property (@(posedge clk) disable iff (!rst_n)
    grace_q <= G_LAST);
  // R7: the idle count resets whenever the block leaves the armed window
  a_r7_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (quiet_q == '0));
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm #(
  parameter int OFS_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic                       grace_done,
  input  logic                       sync_mode,
  input  logic                       rx_dir,
  input  logic [OFS_W-1:0]           offset_cnt,
  input  logic                       fifo_empty,
  input  logic                       clear_halt,
  output xfer_halt_pkg::halt_state_e state
);
  import xfer_halt_pkg::*;

  halt_state_e nxt;
  halt_state_e after_drain;

  assign after_drain = rx_dir ? HS_FLUSH : HS_HALTED;

  always_comb begin
    nxt = state;
    unique case (state)
      HS_IDLE:   if (fire) nxt = HS_ARMED;
      HS_ARMED:  if (grace_done) nxt = sync_mode ? HS_DRAIN : after_drain;
      HS_DRAIN:  if (offset_cnt == '0) nxt = after_drain;
      HS_FLUSH:  if (fifo_empty) nxt = HS_HALTED;
      HS_HALTED: if (clear_halt) nxt = HS_IDLE;
      default:   nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= HS_IDLE;
    else        state <= nxt;
  end

  // R8: offsets still outstanding keep the drain step
  a_r8_drain_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_DRAIN && offset_cnt != '0) |=> state == HS_DRAIN);
  // R9: the flush step holds while data remains
  a_r9_flush_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_FLUSH && !fifo_empty) |=> state == HS_FLUSH);
  // R11: a halt is held until released
  a_r11_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_HALTED && !clear_halt) |=> state == HS_HALTED);
endmodule

// File: rtl/xfer_halt_ctrl.sv
module xfer_halt_ctrl #(
  parameter int OFS_W      = 5,
  parameter int GRACE_MAX  = 3,
  parameter int IDLE_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             target_mode,
  input  logic             halt_disable,
  input  logic             sync_mode,
  input  logic             rx_dir,
  input  logic             byte_strobe,
  input  logic             err_pulse,
  input  logic             atn,
  input  logic [OFS_W-1:0] offset_cnt,
  input  logic             fifo_empty,
  input  logic             clear_halt,
  output logic             stop_req,
  output logic             flush_req,
  output logic             halted,
  output logic [1:0]       halt_cause
);
  import xfer_halt_pkg::*;

  halt_state_e st;
  logic        fire;
  logic        grace_done;
  logic        release_w;

  assign release_w = (st == HS_HALTED) && clear_halt;

  halt_trigger u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .target_mode  (target_mode),
    .halt_disable (halt_disable),
    .err_pulse    (err_pulse),
    .atn          (atn),
    .is_idle      (st == HS_IDLE),
    .release_i    (release_w),
    .fire         (fire),
    .cause        (halt_cause)
  );

  grace_counter #(.GRACE_MAX(GRACE_MAX), .IDLE_LIMIT(IDLE_LIMIT)) u_grace (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (st == HS_ARMED),
    .byte_strobe (byte_strobe),
    .done        (grace_done)
  );

  halt_fsm #(.OFS_W(OFS_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .grace_done (grace_done),
    .sync_mode  (sync_mode),
    .rx_dir     (rx_dir),
    .offset_cnt (offset_cnt),
    .fifo_empty (fifo_empty),
    .clear_halt (clear_halt),
    .state      (st)
  );

  assign stop_req  = (st == HS_DRAIN) || (st == HS_FLUSH) || (st == HS_HALTED);
  assign flush_req = (st == HS_FLUSH);
  assign halted    = (st == HS_HALTED);

  // R4: disabled halting keeps the block idle
  a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_IDLE && halt_disable) |=> st == HS_IDLE);
  // R5: initiator mode never arms
  a_r5_initiator_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_IDLE && !target_mode) |=> st == HS_IDLE);
  // R2: any halt in progress carries a cause
  a_r2_cause_present: assert property (@(posedge clk) disable iff (!rst_n)
    (st != HS_IDLE) |-> (halt_cause != 2'b00));
  // R9: a send never requests a flush
  a_r9_no_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_dir && $stable(rx_dir) && st == HS_ARMED) |=> !flush_req);
endmodule

// File: tb/xfer_halt_ctrl_tb_top.sv
module xfer_halt_ctrl_tb_top;
  localparam int OFS_W = 5;
  localparam int IDLE_LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic target_mode = 1'b1, halt_disable = 1'b0, sync_mode = 1'b0, rx_dir = 1'b0;
  logic byte_strobe = 1'b0, err_pulse = 1'b0, atn = 1'b0, fifo_empty = 1'b1, clear_halt = 1'b0;
  logic [OFS_W-1:0] offset_cnt = '0;
  logic stop_req, flush_req, halted;
  logic [1:0] halt_cause;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  xfer_halt_ctrl #(.OFS_W(OFS_W), .GRACE_MAX(3), .IDLE_LIMIT(IDLE_LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .target_mode(target_mode), .halt_disable(halt_disable),
    .sync_mode(sync_mode), .rx_dir(rx_dir), .byte_strobe(byte_strobe),
    .err_pulse(err_pulse), .atn(atn), .offset_cnt(offset_cnt), .fifo_empty(fifo_empty),
    .clear_halt(clear_halt), .stop_req(stop_req), .flush_req(flush_req),
    .halted(halted), .halt_cause(halt_cause)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_halt();
    clear_halt = 1'b1; step(); clear_halt = 1'b0;
    chk("R11 released", {1'b0, stop_req, flush_req, halted}, 4'h0);
    chk("R10 cause cleared", {2'b0, halt_cause}, 4'h0);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {1'b0, stop_req, flush_req, halted}, 4'h0);
    chk("R1 reset cause", {2'b0, halt_cause}, 4'h0);
  endtask

  task automatic t_err_async_tx();
    err_pulse = 1'b1; step(); err_pulse = 1'b0;
    chk("R2 cause err", {2'b0, halt_cause}, 4'h1);
    chk("R2 armed no stop", {3'b0, stop_req}, 4'h0);
    byte_strobe = 1'b1; step(2);
    chk("R6 two strobes no stop", {3'b0, stop_req}, 4'h0);
    step(); byte_strobe = 1'b0;
    chk("R6 third strobe stops", {1'b0, stop_req, flush_req, halted}, 4'h5);
    atn = 1'b1; step(); atn = 1'b0; err_pulse = 1'b1; step(); err_pulse = 1'b0;
    chk("R10 cause sticky", {2'b0, halt_cause}, 4'h1);
    step(5);
    chk("R11 held", {3'b0, halted}, 4'h1);
    release_halt();
  endtask

  task automatic t_atn_idle();
    atn = 1'b1; step(); atn = 1'b0;
    chk("R3 cause atn", {2'b0, halt_cause}, 4'h2);
    step(IDLE_LIMIT - 1);
    chk("R7 before timeout", {3'b0, stop_req}, 4'h0);
    step();
    chk("R7 timeout halts", {1'b0, stop_req, flush_req, halted}, 4'h5);
    release_halt();
  endtask

  task automatic t_both();
    atn = 1'b1; err_pulse = 1'b1; step(); atn = 1'b0; err_pulse = 1'b0;
    chk("R3 cause both", {2'b0, halt_cause}, 4'h3);
    step(IDLE_LIMIT);
    chk("R3 halted", {3'b0, halted}, 4'h1);
    release_halt();
  endtask

  task automatic t_ignored(input string tag);
    err_pulse = 1'b1; atn = 1'b1; byte_strobe = 1'b1; step();
    err_pulse = 1'b0; step(IDLE_LIMIT + 4);
    chk({tag, " no stop"}, {1'b0, stop_req, flush_req, halted}, 4'h0);
    chk({tag, " no cause"}, {2'b0, halt_cause}, 4'h0);
    atn = 1'b0; byte_strobe = 1'b0; step();
  endtask

  task automatic t_sync_rx();
    sync_mode = 1'b1; rx_dir = 1'b1; offset_cnt = 5'd3; fifo_empty = 1'b0;
    err_pulse = 1'b1; step(); err_pulse = 1'b0;
    byte_strobe = 1'b1; step(3); byte_strobe = 1'b0;
    chk("R8 draining", {1'b0, stop_req, flush_req, halted}, 4'h4);
    step(3);
    chk("R8 still draining", {1'b0, stop_req, flush_req, halted}, 4'h4);
    offset_cnt = '0; step();
    chk("R9 flushing", {1'b0, stop_req, flush_req, halted}, 4'h6);
    step(2);
    chk("R9 flush holds", {1'b0, stop_req, flush_req, halted}, 4'h6);
    fifo_empty = 1'b1; step();
    chk("R9 halted after flush", {1'b0, stop_req, flush_req, halted}, 4'h5);
    release_halt();
  endtask

  task automatic t_sync_tx();
    sync_mode = 1'b1; rx_dir = 1'b0; offset_cnt = '0; fifo_empty = 1'b0;
    atn = 1'b1; step(); atn = 1'b0;
    byte_strobe = 1'b1; step(3); byte_strobe = 1'b0;
    chk("R8 drain step", {1'b0, stop_req, flush_req, halted}, 4'h4);
    step();
    chk("R9 send skips flush", {1'b0, stop_req, flush_req, halted}, 4'h5);
    release_halt();
    sync_mode = 1'b0; fifo_empty = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_err_async_tx();
    t_atn_idle();
    t_both();
    halt_disable = 1'b1; t_ignored("R4"); halt_disable = 1'b0;
    target_mode = 1'b0; t_ignored("R5 dis0");
    halt_disable = 1'b1; t_ignored("R5 dis1"); halt_disable = 1'b0; target_mode = 1'b1;
    t_sync_rx();
    t_sync_tx();
    t_err_async_tx();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule